// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Error Flags

This block takes an asynchronous serial line and a clock that runs at sixteen times the bit rate, and turns each incoming character into a parallel word. The word goes into a single-entry holding buffer, and a set of sticky line-status flags goes with it. The line input first passes through a two-stage synchronizer. A start bit must then stay low for half a bit time before the block accepts it. After that, every data bit and the optional parity bit is sampled once per sixteen clocks, and exactly one stop bit is sampled.

Software-side logic reads the received word with a one-cycle buffer-read strobe and clears the error flags with a one-cycle status-read strobe. An active-low ready output mirrors the data-ready flag. The character format comes from static inputs: word length, parity enable, even/odd select and stick-parity select. A line held low for longer than a complete character is reported as a break, and only once per low period. A bad stop bit that is not part of a break is taken as the start of the next character, so the block stays aligned with a sender that runs slightly fast.

Top module: `uart_rx_line`

## Requirements
- R1: A start bit is accepted only after the synchronized line has been sampled low on 8 consecutive clocks. A low pulse of 7 clocks or fewer returns the receiver to idle and produces no character.
- R2: After the start is accepted, the first data bit is sampled 16 clocks later and each later bit 16 clocks after the previous one. Data arrives least significant bit first and lands in `rx_data` bit 0 upward, with unused upper bits read as 0.
- R3: `word_len` selects the character length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R4: Every completed character, including one with errors, is written to `rx_data` and sets `flag_dr`. `rx_ready_n` is always the inverse of `flag_dr`.
- R5: When `par_en` is 1, a parity bit follows the data. With `par_stick`=0, `par_even`=1 expects an even count of ones over data plus parity, and `par_even`=0 expects an odd count. With `par_stick`=1, the parity bit must be 1 when `par_even`=0 and 0 when `par_even`=1. A mismatch sets `flag_pe`. When `par_en` is 0, `flag_pe` is never set.
- R6: Exactly one stop bit is sampled, one bit time after the last data or parity bit. A low sample sets `flag_fe`. A high line right after that single stop bit can begin the next character.
- R7: If a character completes while `flag_dr` is already 1, `flag_oe` is set and the older word is replaced.
- R8: A `status_rd` pulse clears `flag_oe`, `flag_pe`, `flag_fe` and `flag_bi` on the next clock edge and leaves `flag_dr` and `rx_data` unchanged.
- R9: A `data_rd` pulse clears `flag_dr` on the next clock edge, unless a character completes on the same edge.
- R10: A character whose data, parity (if enabled) and stop samples are all low is a break. It sets `flag_bi` and `flag_fe` together, stores a zero word and sets `flag_dr`. No further character or break is reported until the line has gone high again.
- R11: After a low stop sample that is not a break, that sample counts as the first low sample of a new start bit. A character that follows the bad stop at once is received correctly.
- R12: While `rst_n` is low, all flags are 0, `rx_data` is 0 and `rx_ready_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select, or the inverse stick level |
| par_stick | input | 1 | Fixed-level parity select |
| status_rd | input | 1 | One-cycle strobe clearing the error flags |
| data_rd | input | 1 | One-cycle strobe taking the buffered word |
| rx_data | output | 8 | Last received word |
| flag_dr | output | 1 | Word waiting in the buffer |
| flag_oe | output | 1 | Overrun: an unread word was replaced |
| flag_pe | output | 1 | Parity mismatch |
| flag_fe | output | 1 | Low stop sample |
| flag_bi | output | 1 | Break seen |
| rx_ready_n | output | 1 | Active-low copy of `flag_dr` |

## Verification
Any level on `rx_in` reaches the receiver two clocks later because of the synchronizer. The stop sample therefore lands about nine clocks into the stop bit, and the buffer and flags change two clock edges after that sample. So every character check waits at least 32 idle clocks after the stop bit before it samples. A read strobe acts on the next rising edge, and the bench drives each strobe at a falling edge and checks its effect at the following falling edge. Start-qualification and break checks hold the line low for exact clock counts (7, 8, twelve bit times). The observation windows are chosen so that any spurious character would have finished by the time the outputs are read.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rx_state_t;
endpackage

// File: rtl/rxl_sync.sv
module rxl_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rxl_frame.sv
module rxl_frame
  import rxl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_pe,
  output logic              done_fe,
  output logic              done_bi
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] QUAL_END = CNT_W'(OSR / 2 - 2);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(OSR - 1);

  rx_state_t         st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [IDX_W-1:0]  idx, idx_n, last_idx;
  logic [DATA_W-1:0] sr, sr_n;
  logic              pbit, pbit_n;
  logic              done_n, pe_n, fe_n, bi_n;
  logic              exp_par, is_brk;

  assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(word_len);
  assign exp_par  = par_stick ? ~par_even : (par_even ? ^sr : ~^sr);
  assign is_brk   = ~rxs && (sr == '0) && (~par_en || ~pbit);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    sr_n   = sr;
    pbit_n = pbit;
    done_n = 1'b0;
    pe_n   = 1'b0;
    fe_n   = 1'b0;
    bi_n   = 1'b0;
    case (st)
      RX_IDLE: begin
        if (!rxs) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
      end
      RX_START: begin
        if (rxs) begin
          st_n = RX_IDLE;
        end else if (cnt == QUAL_END) begin
          st_n  = RX_DATA;
          cnt_n = '0;
          idx_n = '0;
          sr_n  = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt == BIT_END) begin
          cnt_n     = '0;
          sr_n[idx] = rxs;
          if (idx == last_idx) st_n = par_en ? RX_PAR : RX_STOP;
          else                 idx_n = idx + 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      RX_PAR: begin
        if (cnt == BIT_END) begin
          cnt_n  = '0;
          pbit_n = rxs;
          st_n   = RX_STOP;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt == BIT_END) begin
          cnt_n  = '0;
          done_n = 1'b1;
          fe_n   = ~rxs;
          pe_n   = par_en && (pbit != exp_par);
          bi_n   = is_brk;
          if (rxs)         st_n = RX_IDLE;
          else if (is_brk) st_n = RX_BRK;
          else             st_n = RX_START;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      RX_BRK: begin
        if (rxs) st_n = RX_IDLE;
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sr        <= '0;
      pbit      <= 1'b0;
      done      <= 1'b0;
      done_pe   <= 1'b0;
      done_fe   <= 1'b0;
      done_bi   <= 1'b0;
      done_data <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      idx     <= idx_n;
      sr      <= sr_n;
      pbit    <= pbit_n;
      done    <= done_n;
      done_pe <= pe_n;
      done_fe <= fe_n;
      done_bi <= bi_n;
      if (done_n) done_data <= sr;
    end
  end

  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && rxs) |=> (st == RX_IDLE)); // R1

  AST_DATA_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && $past(st) == RX_START && st_n == RX_DATA) |-> (!rxs && !$past(rxs))); // R1

  AST_BRK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_BRK && $past(st) == RX_BRK) |-> !done); // R10

  AST_PE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_STOP && !par_en) |=> !done_pe); // R5
endmodule

// File: rtl/rxl_status.sv
module rxl_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_pe,
  input  logic              done_fe,
  input  logic              done_bi,
  input  logic              status_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] buf_q,
  output logic              dr_q,
  output logic              oe_q,
  output logic              pe_q,
  output logic              fe_q,
  output logic              bi_q
);
  logic dr_n, oe_n, pe_n, fe_n, bi_n;

  always_comb begin
    dr_n = done ? 1'b1 : (data_rd ? 1'b0 : dr_q);
    oe_n = (status_rd ? 1'b0 : oe_q) | (done & dr_q);
    pe_n = (status_rd ? 1'b0 : pe_q) | (done & done_pe);
    fe_n = (status_rd ? 1'b0 : fe_q) | (done & done_fe);
    bi_n = (status_rd ? 1'b0 : bi_q) | (done & done_bi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      if (done) buf_q <= done_data;
      dr_q <= dr_n;
      oe_q <= oe_n;
      pe_q <= pe_n;
      fe_q <= fe_n;
      bi_q <= bi_n;
    end
  end

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr_q) |=> oe_q); // R7

  AST_DONE_SETS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> dr_q); // R4

  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !dr_q); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !done) |=> (!oe_q && !pe_q && !fe_q && !bi_q)); // R8

  AST_STATUS_KEEPS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !done && !data_rd) |=> (dr_q == $past(dr_q))); // R8

  AST_BI_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bi_q) |-> fe_q); // R10
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              status_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              flag_dr,
  output logic              flag_oe,
  output logic              flag_pe,
  output logic              flag_fe,
  output logic              flag_bi,
  output logic              rx_ready_n
);
  logic              rst_sync_n;
  logic              rxs;
  logic              fr_done, fr_pe, fr_fe, fr_bi;
  logic [DATA_W-1:0] fr_data;

  rxl_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (1'b1),
    .d_out (rst_sync_n)
  );

  rxl_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (rx_in),
    .d_out (rxs)
  );

  rxl_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rxs       (rxs),
    .word_len  (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .done      (fr_done),
    .done_data (fr_data),
    .done_pe   (fr_pe),
    .done_fe   (fr_fe),
    .done_bi   (fr_bi)
  );

  rxl_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .done      (fr_done),
    .done_data (fr_data),
    .done_pe   (fr_pe),
    .done_fe   (fr_fe),
    .done_bi   (fr_bi),
    .status_rd (status_rd),
    .data_rd   (data_rd),
    .buf_q     (rx_data),
    .dr_q      (flag_dr),
    .oe_q      (flag_oe),
    .pe_q      (flag_pe),
    .fe_q      (flag_fe),
    .bi_q      (flag_bi)
  );

  assign rx_ready_n = ~flag_dr;

  AST_FE_ON_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fr_done && fr_fe) |=> flag_fe); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!flag_dr && !flag_oe && !flag_pe && !flag_fe && !flag_bi)); // R12
endmodule

// File: tb/tb_uart_rx_line.sv
module tb_uart_rx_line;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_in;
  logic [1:0] word_len;
  logic       par_en, par_even, par_stick;
  logic       status_rd, data_rd;
  logic [7:0] rx_data;
  logic       flag_dr, flag_oe, flag_pe, flag_fe, flag_bi, rx_ready_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_line dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .status_rd(status_rd), .data_rd(data_rd), .rx_data(rx_data),
    .flag_dr(flag_dr), .flag_oe(flag_oe), .flag_pe(flag_pe),
    .flag_fe(flag_fe), .flag_bi(flag_bi), .rx_ready_n(rx_ready_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    idle(n);
  endtask

  task automatic pulse_rd(input logic s, input logic d);
    @(negedge clk);
    status_rd = s;
    data_rd   = d;
    @(negedge clk);
    status_rd = 1'b0;
    data_rd   = 1'b0;
  endtask

  function automatic logic exp_parity(input logic [7:0] d);
    if (par_stick) return ~par_even;
    return par_even ? ^d : ~^d;
  endfunction

  task automatic send(input logic [7:0] d, input int nbits, input logic has_par,
                      input logic pval, input logic stop_val, input int stop_clks);
    hold(1'b0, 16);
    for (int i = 0; i < nbits; i++) hold(d[i], 16);
    if (has_par) hold(pval, 16);
    if (stop_clks > 0) hold(stop_val, stop_clks);
    rx_in = 1'b1;
  endtask

  task automatic t_reset;
    chk("R12 dr", {7'd0, flag_dr}, 8'd0);
    chk("R12 ready_n", {7'd0, rx_ready_n}, 8'd1);
    chk("R12 errs", {4'd0, flag_oe, flag_pe, flag_fe, flag_bi}, 8'd0);
    chk("R12 data", rx_data, 8'd0);
  endtask

  task automatic t_start_qual;
    hold(1'b0, 7); hold(1'b1, 300);
    chk("R1 7-clock glitch ignored", {7'd0, flag_dr}, 8'd0);
    hold(1'b0, 8); hold(1'b1, 300);
    chk("R1 8-clock low accepted dr", {7'd0, flag_dr}, 8'd1);
    chk("R1 8-clock low data", rx_data, 8'hFF);
    pulse_rd(1'b1, 1'b1);
  endtask

  task automatic t_basic;
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R4 dr set", {7'd0, flag_dr}, 8'd1);
    chk("R4 ready_n low", {7'd0, rx_ready_n}, 8'd0);
    chk("R6 no fe", {7'd0, flag_fe}, 8'd0);
    pulse_rd(1'b0, 1'b1);
    chk("R9 dr cleared", {7'd0, flag_dr}, 8'd0);
    chk("R9 ready_n high", {7'd0, rx_ready_n}, 8'd1);
  endtask

  task automatic t_lengths;
    word_len = 2'b00; send(8'h13, 5, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R3 5-bit", rx_data, 8'h13); pulse_rd(1'b1, 1'b1);
    word_len = 2'b01; send(8'h2A, 6, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R3 6-bit", rx_data, 8'h2A); pulse_rd(1'b1, 1'b1);
    word_len = 2'b10; send(8'h55, 7, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R3 7-bit", rx_data, 8'h55); pulse_rd(1'b1, 1'b1);
    word_len = 2'b11;
  endtask

  task automatic t_parity;
    par_en = 1'b1;
    par_stick = 1'b0; par_even = 1'b1;
    send(8'hA5, 8, 1'b1, exp_parity(8'hA5), 1'b1, 16); idle(32);
    chk("R5 even good", {7'd0, flag_pe}, 8'd0); pulse_rd(1'b1, 1'b1);
    send(8'hA5, 8, 1'b1, ~exp_parity(8'hA5), 1'b1, 16); idle(32);
    chk("R5 even bad", {7'd0, flag_pe}, 8'd1);
    chk("R4 data kept on error", rx_data, 8'hA5); pulse_rd(1'b1, 1'b1);
    par_even = 1'b0;
    send(8'h07, 8, 1'b1, exp_parity(8'h07), 1'b1, 16); idle(32);
    chk("R5 odd good", {7'd0, flag_pe}, 8'd0); pulse_rd(1'b1, 1'b1);
    send(8'h07, 8, 1'b1, ~exp_parity(8'h07), 1'b1, 16); idle(32);
    chk("R5 odd bad", {7'd0, flag_pe}, 8'd1); pulse_rd(1'b1, 1'b1);
    par_stick = 1'b1; par_even = 1'b0;
    send(8'h3C, 8, 1'b1, 1'b0, 1'b1, 16); idle(32);
    chk("R5 stick-1 bad", {7'd0, flag_pe}, 8'd1); pulse_rd(1'b1, 1'b1);
    par_even = 1'b1;
    send(8'h3C, 8, 1'b1, 1'b0, 1'b1, 16); idle(32);
    chk("R5 stick-0 good", {7'd0, flag_pe}, 8'd0); pulse_rd(1'b1, 1'b1);
    par_en = 1'b0; par_stick = 1'b0;
  endtask

  task automatic t_frame_err;
    send(8'h3C, 8, 1'b0, 1'b0, 1'b0, 10); idle(300);
    chk("R6 fe set", {7'd0, flag_fe}, 8'd1);
    chk("R6 data", rx_data, 8'h3C);
    chk("R6 no break", {7'd0, flag_bi}, 8'd0);
    pulse_rd(1'b1, 1'b0);
    chk("R8 fe cleared", {7'd0, flag_fe}, 8'd0);
    chk("R8 dr kept", {7'd0, flag_dr}, 8'd1);
    chk("R8 data kept", rx_data, 8'h3C);
    pulse_rd(1'b0, 1'b1);
  endtask

  task automatic t_back_to_back;
    send(8'h81, 8, 1'b0, 1'b0, 1'b1, 16);
    send(8'h42, 8, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R6 single stop then next char", rx_data, 8'h42);
    chk("R6 back-to-back no fe", {7'd0, flag_fe}, 8'd0);
    chk("R7 overrun set", {7'd0, flag_oe}, 8'd1);
    chk("R7 dr still set", {7'd0, flag_dr}, 8'd1);
    pulse_rd(1'b1, 1'b1);
    chk("R8 oe cleared", {7'd0, flag_oe}, 8'd0);
  endtask

  task automatic t_resync;
    send(8'h3C, 8, 1'b0, 1'b0, 1'b0, 0);
    send(8'h5A, 8, 1'b0, 1'b0, 1'b1, 16); idle(300);
    chk("R11 next char after bad stop", rx_data, 8'h5A);
    chk("R11 fe from first", {7'd0, flag_fe}, 8'd1);
    chk("R11 overrun from pair", {7'd0, flag_oe}, 8'd1);
    pulse_rd(1'b1, 1'b1);
  endtask

  task automatic t_break;
    hold(1'b0, 192);
    chk("R10 bi set", {7'd0, flag_bi}, 8'd1);
    chk("R10 fe with bi", {7'd0, flag_fe}, 8'd1);
    chk("R10 zero word", rx_data, 8'h00);
    chk("R10 dr set", {7'd0, flag_dr}, 8'd1);
    pulse_rd(1'b1, 1'b1);
    hold(1'b0, 400);
    chk("R10 bi not repeated", {7'd0, flag_bi}, 8'd0);
    chk("R10 no new char", {7'd0, flag_dr}, 8'd0);
    hold(1'b1, 64);
    chk("R10 bi stays clear after release", {7'd0, flag_bi}, 8'd0);
    send(8'h6E, 8, 1'b0, 1'b0, 1'b1, 16); idle(32);
    chk("R10 receive after break", rx_data, 8'h6E);
  endtask

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; word_len = 2'b11;
    par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;
    status_rd = 1'b0; data_rd = 1'b0;
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(8);
    t_start_qual();
    t_basic();
    t_lengths();
    t_parity();
    t_frame_err();
    t_back_to_back();
    t_resync();
    t_break();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule